// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves 8-bit words over three lines: a shift clock, a serial output and a serial input. Both directions run at once, so each word sent also brings one word in. A parallel side loads the outgoing word with a one-cycle write strobe. The word that arrived is held on a read bus until the next word completes.

A run-time control input sets who drives the shift clock. As master, the block makes the clock from its own system clock. The clock sits low when idle and gives eight pulses per word. Each half period lasts a programmable number of system cycles. As slave, the block takes the clock from a pin. It passes that clock through a two-stage synchroniser and detects edges in the system clock domain, so the system clock must run at least four times faster than the external clock. In slave mode an edge-select input picks the active edge. In master mode the rising edge is always the active one.

A one-cycle completion pulse marks the end of every word. If the write strobe arrives while a word is still in flight, the write is dropped and a collision flag is raised.

Top module: `serShiftPort`

## Requirements
- R1: After reset, `rdData` is 0, `done`, `busy`, `wrCollision` and `sclkOut` are 0, and `sclkOe` is the inverse of `clkDirExt`.
- R2: With `clkDirExt`=0 the block drives `sclkOut` (`sclkOe`=1). A write produces exactly 8 rising pulses, and `sclkOut` rests low before and after the word.
- R3: In master mode, every low phase and every high phase of `sclkOut` lasts `divHalf` system cycles, so the 8 high phases total 8*`divHalf` cycles.
- R4: In master mode, `sdo` changes only on a rising edge of `sclkOut`. The word leaves least significant bit first: bit k is on `sdo` from rising edge k (counting from 0) until the next rising edge.
- R5: In master mode, `sdi` is sampled at each rising edge of `sclkOut`. The first sampled bit becomes bit 0 of the received word.
- R6: With `clkDirExt`=1 and `edgeSel`=0, each rising edge of `sclkIn` samples `sdi` and shifts the next output bit, LSB first, onto `sdo`.
- R7: With `clkDirExt`=1 and `edgeSel`=1, the falling edge of `sclkIn` takes over the role of the rising edge, and rising edges have no effect.
- R8: After the 8th bit, `rdData` takes the received word and `done` is high for exactly one cycle. `busy`, set by an accepted write, is low from that cycle on.
- R9: A write while `busy` is 1 is dropped: the word in flight goes out unchanged and `wrCollision` goes to 1. The next accepted write clears `wrCollision`.
- R10: In slave mode, `sclkIn` edges seen while no word is loaded (`busy`=0) cause no `done` pulse and leave `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkDirExt | input | 1 | 0: block drives the shift clock, 1: shift clock comes from `sclkIn` |
| edgeSel | input | 1 | Slave active edge: 0 rising, 1 falling |
| divHalf | input | DIV_W | System cycles per half period of the master shift clock |
| wrEn | input | 1 | Write strobe for the outgoing word |
| wrData | input | WORD_W | Outgoing word |
| rdData | output | WORD_W | Last received word |
| busy | output | 1 | Word loaded and not yet complete |
| done | output | 1 | One-cycle completion pulse |
| wrCollision | output | 1 | Set by a write during a transfer |
| sclkOut | output | 1 | Shift clock driven in master mode |
| sclkOe | output | 1 | Output enable for the shift clock pin |
| sclkIn | input | 1 | Shift clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench acts as the far end of the link. It changes `sdi` only on the inactive edge of the shift clock, so a design that samples on the wrong edge picks up the next bit and returns a shifted word. Outgoing bits are collected on inactive edges and compared LSB first against the written word, which exposes a reversed bit order or an output that moves on the wrong edge. The master clock is measured by counting its rising edges and its high cycles, which catches an off-by-one pulse count or a wrong half period. The bench also writes in the middle of a transfer, to catch a design that corrupts the word in flight or never raises the flag. Finally it toggles the external clock while idle, to catch a design that counts stray edges into a phantom word.

// File: rtl/serShiftPkg.sv
package serShiftPkg;
  // strobes the control unit hands to the datapath each cycle
  typedef struct packed {
    logic load;     // take the outgoing word
    logic shift;    // active shift-clock edge: move one bit each way
    logic capture;  // word complete: copy received bits to the read register
  } shiftStrobeT;
endpackage

// File: rtl/serShiftCtrl.sv
module serShiftCtrl
  import serShiftPkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkDirExt,
  input  logic             edgeSel,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             wrEn,
  input  logic             sclkIn,
  output shiftStrobeT      strobe,
  output logic             busy,
  output logic             done,
  output logic             wrCollision,
  output logic             sclkOut
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES:0] syncQ;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0] nextCnt;
  logic sclkReg, pendCap;
  logic riseDet, fallDet, activeExt;
  logic accept, divDone, masterRise, masterFall, extShift;

  // external clock synchroniser plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sclkIn};
  end

  always_comb begin
    riseDet   = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    fallDet   = ~syncQ[SYNC_STAGES-1] & syncQ[SYNC_STAGES];
    activeExt = edgeSel ? fallDet : riseDet;
    nextCnt   = {1'b0, divCnt} + 1'b1;
    divDone   = nextCnt >= {1'b0, divHalf};
    accept    = wrEn & ~busy;
    masterRise = busy & ~clkDirExt & divDone & ~sclkReg;
    masterFall = busy & ~clkDirExt & divDone & sclkReg;
    extShift   = busy & clkDirExt & activeExt & ~pendCap;
    strobe.load    = accept;
    strobe.shift   = masterRise | extShift;
    strobe.capture = (masterFall & (bitCnt == LAST_CNT)) | (busy & clkDirExt & pendCap);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      wrCollision <= 1'b0;
      sclkReg     <= 1'b0;
      pendCap     <= 1'b0;
      bitCnt      <= '0;
      divCnt      <= '0;
    end else begin
      done <= strobe.capture;
      if (accept) begin
        busy        <= 1'b1;
        wrCollision <= 1'b0;
        bitCnt      <= '0;
        divCnt      <= '0;
        sclkReg     <= 1'b0;
        pendCap     <= 1'b0;
      end else begin
        if (wrEn) wrCollision <= 1'b1;
        if (busy && !clkDirExt) begin
          divCnt <= divDone ? '0 : nextCnt[DIV_W-1:0];
          if (divDone) sclkReg <= ~sclkReg;
        end
        if (strobe.shift) begin
          bitCnt <= bitCnt + 1'b1;
          if (extShift && bitCnt == PRE_LAST) pendCap <= 1'b1;
        end
        if (strobe.capture) begin
          busy    <= 1'b0;
          pendCap <= 1'b0;
          sclkReg <= 1'b0;
        end
      end
    end
  end

  assign sclkOut = sclkReg & ~clkDirExt;
endmodule

// File: rtl/serShiftData.sv
module serShiftData
  import serShiftPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobeT       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              sdi,
  output logic              sdo,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      sdo     <= 1'b0;
    end else begin
      if (strobe.load) txShift <= wrData;
      else if (strobe.shift) begin
        sdo     <= txShift[0];
        txShift <= {1'b0, txShift[WORD_W-1:1]};
        rxShift <= {sdi, rxShift[WORD_W-1:1]};
      end
      if (strobe.capture) rdData <= rxShift;
    end
  end
endmodule

// File: rtl/serShiftPort.sv
module serShiftPort
  import serShiftPkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkDirExt,
  input  logic              edgeSel,
  input  logic [DIV_W-1:0]  divHalf,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              wrCollision,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              sclkIn,
  output logic              sdo,
  input  logic              sdi
);
  shiftStrobeT strobe;

  serShiftCtrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkDirExt(clkDirExt), .edgeSel(edgeSel),
    .divHalf(divHalf), .wrEn(wrEn), .sclkIn(sclkIn), .strobe(strobe),
    .busy(busy), .done(done), .wrCollision(wrCollision), .sclkOut(sclkOut)
  );

  serShiftData #(.WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .sdi(sdi), .sdo(sdo), .rdData(rdData)
  );

  assign sclkOe = ~clkDirExt;
endmodule

// File: rtl/serShiftChecker.sv
module serShiftChecker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkDirExt,
  input logic              wrEn,
  input logic              busy,
  input logic              done,
  input logic              wrCollision,
  input logic              sclkOut,
  input logic              sdo,
  input logic [WORD_W-1:0] rdData
);
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !clkDirExt) |-> !sclkOut);

  a_r4_sdo_holds_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (!clkDirExt && sclkOut && $past(sclkOut)) |-> $stable(sdo));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_collision_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> wrCollision);

  a_r10_rd_stable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(rdData));
endmodule

bind serShiftPort serShiftChecker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkDirExt(clkDirExt), .wrEn(wrEn), .busy(busy),
  .done(done), .wrCollision(wrCollision), .sclkOut(sclkOut), .sdo(sdo),
  .rdData(rdData)
);

// File: tb/test_serShiftPort.sv
`timescale 1ns/1ps
module test_serShiftPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkDirExt = 1'b0;
  logic edgeSel = 1'b0;
  logic [7:0] divHalf = 8'd2;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic busy, done, wrCollision, sclkOut, sclkOe, sdo;
  logic sclkIn = 1'b0;
  logic sdi = 1'b0;
  int checkCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  serShiftPort i_serShiftPort (
    .clk(clk), .rstN(rstN), .clkDirExt(clkDirExt), .edgeSel(edgeSel),
    .divHalf(divHalf), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .busy(busy), .done(done), .wrCollision(wrCollision), .sclkOut(sclkOut),
    .sclkOe(sclkOe), .sclkIn(sclkIn), .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rdData", rdData, 0);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 wrCollision", wrCollision, 0);
    check("R1 sclkOut", sclkOut, 0);
    check("R1 sclkOe", sclkOe, 1);
  endtask

  // master transfer; collideAt < 0 means no second write
  task automatic runMaster(input logic [7:0] tx, input logic [7:0] rx,
                           input logic [7:0] half, input int collideAt);
    int bitIdx = 0;
    int highCnt = 0;
    int rises = 0;
    logic prevS = 1'b0;
    logic [7:0] got = 8'h00;
    bit seen = 0;
    clkDirExt = 1'b0;
    divHalf = half;
    sdi = rx[0];
    @(negedge clk);
    check("R2 sclkOe master", sclkOe, 1);
    wrEn = 1'b1;
    wrData = tx;
    for (int cyc = 0; cyc < 4000 && !seen; cyc++) begin
      @(negedge clk);
      wrEn = (cyc == collideAt);
      if (cyc == collideAt) wrData = 8'hFF;
      if (collideAt >= 0 && cyc == collideAt + 1) check("R9 collision flag", wrCollision, 1);
      if (sclkOut) highCnt++;
      if (sclkOut && !prevS) rises++;
      if (!sclkOut && prevS) begin
        if (bitIdx < 8) got[bitIdx] = sdo;
        bitIdx++;
        if (bitIdx < 8) sdi = rx[bitIdx];
      end
      prevS = sclkOut;
      if (done) seen = 1;
    end
    wrEn = 1'b0;
    check("R8 done seen", seen, 1);
    check("R8 busy low at done", busy, 0);
    check("R5 rdData", rdData, rx);
    check("R4 sdo LSB first", got, tx);
    check("R2 pulse count", rises, 8);
    check("R3 high cycles", highCnt, 8 * half);
    @(negedge clk);
    check("R8 done one cycle", done, 0);
    check("R2 idle low", sclkOut, 0);
  endtask

  // slave transfer driven by the bench; active edge picked by sel
  task automatic runSlave(input logic [7:0] tx, input logic [7:0] rx, input logic sel,
                          input bit idleEdges);
    logic [7:0] got = 8'h00;
    int doneCnt = 0;
    clkDirExt = 1'b1;
    edgeSel = sel;
    sclkIn = sel;
    repeat (6) @(negedge clk);
    check(sel ? "R7 sclkOe slave" : "R6 sclkOe slave", sclkOe, 0);
    wrEn = 1'b1;
    wrData = tx;
    @(negedge clk);
    wrEn = 1'b0;
    check(sel ? "R7 busy after write" : "R6 busy after write", busy, 1);
    for (int k = 0; k < 8; k++) begin
      sdi = rx[k];
      repeat (8) begin @(negedge clk); if (done) doneCnt++; end
      sclkIn = ~sel;
      repeat (8) begin @(negedge clk); if (done) doneCnt++; end
      got[k] = sdo;
      sclkIn = sel;
    end
    repeat (8) begin @(negedge clk); if (done) doneCnt++; end
    check(sel ? "R7 rdData" : "R6 rdData", rdData, rx);
    check(sel ? "R7 sdo LSB first" : "R6 sdo LSB first", got, tx);
    check("R8 single done pulse", doneCnt, 1);
    check("R8 busy cleared", busy, 0);
    if (idleEdges) begin
      doneCnt = 0;
      for (int k = 0; k < 10; k++) begin
        sdi = ~rx[k % 8];
        repeat (6) begin @(negedge clk); if (done) doneCnt++; end
        sclkIn = ~sel;
        repeat (6) begin @(negedge clk); if (done) doneCnt++; end
        sclkIn = sel;
      end
      repeat (6) begin @(negedge clk); if (done) doneCnt++; end
      check("R10 no done when idle", doneCnt, 0);
      check("R10 rdData kept", rdData, rx);
      check("R10 busy stays low", busy, 0);
    end
  endtask

  task automatic testCollisionClear();
    // the write after a collision is accepted and clears the flag
    runMaster(8'h5A, 8'hC3, 8'd3, -1);
    check("R9 flag cleared by accepted write", wrCollision, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    testReset();
    runMaster(8'hA5, 8'h3C, 8'd2, -1);
    runMaster(8'h81, 8'h7E, 8'd5, -1);
    runMaster(8'h96, 8'h1F, 8'd4, 2);
    check("R9 flag still set after word", wrCollision, 1);
    testCollisionClear();
    runSlave(8'hB4, 8'h6D, 1'b0, 1'b1);
    runSlave(8'h2B, 8'hD2, 1'b1, 1'b0);
    finishRun();
  end
endmodule